// File: doc/BRIEF.md
# Peripheral Access Firewall Registers

This block is the configuration and decision point for a peripheral firewall. Each securable peripheral has a 2-bit access attribute and a one-shot lock bit. Both are reached through a flat 32-bit register port with an address, a write strobe, write data and read data. Reads are combinational. Writes take effect on the rising clock edge.

For every peripheral the block also turns the stored attribute into a grant for the transaction aimed at that peripheral. The decision depends on whether the requester is non-secure and whether the access is a write. A second output per peripheral flags whether that peripheral currently belongs to the secure world. The peripheral count and the identification fields are parameters. Two read-only words report these fields to software.

Top module: `periph_guard`

## Requirements
- R1: After reset every attribute equals 0 (secure read/write) and every lock bit equals 0. All attribute and lock words read as zero.
- R2: The attribute of peripheral n is a 2-bit field at byte address 0x010 + 4*(n/16), bits 2*(n%16)+1 : 2*(n%16). Writing that word sets the field, and the new value reads back.
- R3: The lock bit of peripheral n is bit n%32 of the word at byte address 0x030 + 4*(n/32). Writing a one sets the lock, and a zero in a written bit leaves that lock as it was.
- R4: A peripheral whose lock is set ignores writes to its attribute field. Unlocked peripherals in the same word still take the written value.
- R5: No register write clears a lock bit. Only reset clears it.
- R6: The word at 0x3F0 reads {chunk count[31:24], bus-master zone count[23:16], peripheral count[15:8], memory zone count[7:0]}, all taken from parameters. Writes to it have no effect. Unmapped addresses read as zero.
- R7: The word at 0x3F4 reads the revision parameter in bits 7:0 and zero above.
- R8: Attribute fields and lock bits for identifiers at or above the peripheral count read as zero and keep zero after writes.
- R9: A non-secure write (acc_ns=1, acc_wr=1) is granted only when the attribute is 3 (non-secure read/write).
- R10: A non-secure read (acc_ns=1, acc_wr=0) is granted when the attribute is 1 (non-secure read, secure write) or 3. It is refused for 0 and for 2 (coprocessor isolation).
- R11: A secure requester (acc_ns=0) is always granted.
- R12: acc_owned is 1 exactly when the attribute is 0 or 1.
- R13: The decision outputs follow the stored attribute. A write in the cycle before an edge changes the grant only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| acc_ns | input | NUM_PERIPH | Per peripheral: requester is non-secure |
| acc_wr | input | NUM_PERIPH | Per peripheral: access is a write |
| acc_grant | output | NUM_PERIPH | Per peripheral: access allowed |
| acc_owned | output | NUM_PERIPH | Per peripheral: owned by the secure world |

## Verification
The access decision and a register write to the same attribute can fall in the same cycle. The bench holds a non-secure write request on one peripheral and drives an attribute write that moves that peripheral from 3 to 0. It samples the grant just before the edge, where the old value must still show. It samples again just after the edge, where the refusal must appear. Lock setting and attribute writes to the same word are interleaved in the same way. The bench then checks that locked fields and unlocked fields in that word diverge as the model predicts.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [1:0] {
      PG_SEC_RW  = 2'd0,
      PG_NSR_SW  = 2'd1,
      PG_ISOLATE = 2'd2,
      PG_NS_RW   = 2'd3
   } pg_attr_e;

   localparam int PG_FIELDS_PER_WORD = 16;
   localparam int PG_LOCKS_PER_WORD  = 32;
   localparam int PG_ATTR_BASE_WORD  = 4;    // byte 0x010
   localparam int PG_LOCK_BASE_WORD  = 12;   // byte 0x030
   localparam int PG_HWCFG_WORD      = 252;  // byte 0x3F0
   localparam int PG_VERSION_WORD    = 253;  // byte 0x3F4
   localparam int PG_MAX_ATTR_WORDS  = PG_LOCK_BASE_WORD - PG_ATTR_BASE_WORD;
endpackage

// File: rtl/pg_gate.sv
module pg_gate
   import pg_pkg::*;
(
   input  pg_attr_e attr,
   input  logic     req_ns,
   input  logic     req_wr,
   output logic     grant,
   output logic     owned
);
   always_comb begin
      owned = (attr == PG_SEC_RW) || (attr == PG_NSR_SW);
      if (!req_ns)
         grant = 1'b1;
      else if (req_wr)
         grant = (attr == PG_NS_RW);
      else
         grant = (attr == PG_NSR_SW) || (attr == PG_NS_RW);
   end
endmodule

// File: rtl/pg_slot.sv
module pg_slot
   import pg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_attr,
   input  logic       lock_set,
   input  logic       req_ns,
   input  logic       req_wr,
   output logic [1:0] attr_o,
   output logic       lock_o,
   output logic       grant,
   output logic       owned
);
   pg_attr_e attr_q;
   logic     lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q <= PG_SEC_RW;
         lock_q <= 1'b0;
      end else begin
         if (lock_set)
            lock_q <= 1'b1;
         if (wr_en && !lock_q)
            attr_q <= pg_attr_e'(wr_attr);
      end
   end

   assign attr_o = attr_q;
   assign lock_o = lock_q;

   pg_gate u_gate (
      .attr   (attr_q),
      .req_ns (req_ns),
      .req_wr (req_wr),
      .grant  (grant),
      .owned  (owned)
   );

   a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(attr_q));
   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   a_r13_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(attr_q));
   a_r9_owned_refuses_ns_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ns && req_wr && owned) |-> !grant);
   a_r10_isolation_refuses_ns_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ns && !req_wr && attr_q == PG_ISOLATE) |-> !grant);
   a_r11_secure_always_granted: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ns |-> grant);
endmodule

// File: rtl/periph_guard.sv
module periph_guard
   import pg_pkg::*;
#(
   parameter int         NUM_PERIPH  = 40,
   parameter int         NUM_ZONES   = 2,
   parameter int         NUM_MASTERS = 0,
   parameter int         NUM_CHUNKS  = 0,
   parameter logic [7:0] REVISION    = 8'h20,
   parameter int         ADDR_W      = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_we,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic [NUM_PERIPH-1:0] acc_ns,
   input  logic [NUM_PERIPH-1:0] acc_wr,
   output logic [NUM_PERIPH-1:0] acc_grant,
   output logic [NUM_PERIPH-1:0] acc_owned
);
   localparam int ATTR_WORDS = (NUM_PERIPH + PG_FIELDS_PER_WORD - 1) / PG_FIELDS_PER_WORD;
   localparam int LOCK_WORDS = (NUM_PERIPH + PG_LOCKS_PER_WORD - 1) / PG_LOCKS_PER_WORD;
   localparam int PAD_SLOTS  = NUM_PERIPH % PG_FIELDS_PER_WORD;
   localparam logic [31:0] PAD_MASK =
      (PAD_SLOTS == 0) ? 32'h0 : ~((32'h1 << (2 * PAD_SLOTS)) - 32'h1);

   // elaboration-time parameter checks
   if (NUM_PERIPH < 1 || ATTR_WORDS > PG_MAX_ATTR_WORDS) begin : g_bad_count
      $error("periph_guard: NUM_PERIPH must lie in 1..128");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("periph_guard: ADDR_W must be at least 10");
   end
   if (NUM_ZONES > 255 || NUM_MASTERS > 255 || NUM_CHUNKS > 255 || NUM_PERIPH > 255) begin : g_bad_field
      $error("periph_guard: identification counts must fit in 8 bits");
   end

   logic [31:0]                          widx;
   logic [NUM_PERIPH-1:0][1:0]           attr_q;
   logic [NUM_PERIPH-1:0]                lock_q;
   logic [ATTR_WORDS-1:0][31:0]          attr_words;
   logic [LOCK_WORDS-1:0][31:0]          lock_words;

   assign widx = 32'(reg_addr[ADDR_W-1:2]);

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
      localparam int AW = PG_ATTR_BASE_WORD + i / PG_FIELDS_PER_WORD;
      localparam int AB = 2 * (i % PG_FIELDS_PER_WORD);
      localparam int LW = PG_LOCK_BASE_WORD + i / PG_LOCKS_PER_WORD;
      localparam int LB = i % PG_LOCKS_PER_WORD;
      logic wr_hit;
      logic lock_hit;

      assign wr_hit   = reg_we && (widx == 32'(AW));
      assign lock_hit = reg_we && (widx == 32'(LW)) && reg_wdata[LB];

      pg_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_hit),
         .wr_attr  (reg_wdata[AB+1:AB]),
         .lock_set (lock_hit),
         .req_ns   (acc_ns[i]),
         .req_wr   (acc_wr[i]),
         .attr_o   (attr_q[i]),
         .lock_o   (lock_q[i]),
         .grant    (acc_grant[i]),
         .owned    (acc_owned[i])
      );
   end

   always_comb begin
      attr_words = '0;
      lock_words = '0;
      for (int i = 0; i < NUM_PERIPH; i++) begin
         attr_words[i / PG_FIELDS_PER_WORD][2 * (i % PG_FIELDS_PER_WORD) +: 2] = attr_q[i];
         lock_words[i / PG_LOCKS_PER_WORD][i % PG_LOCKS_PER_WORD]            = lock_q[i];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < ATTR_WORDS; w++)
         if (widx == 32'(PG_ATTR_BASE_WORD + w)) reg_rdata = attr_words[w];
      for (int w = 0; w < LOCK_WORDS; w++)
         if (widx == 32'(PG_LOCK_BASE_WORD + w)) reg_rdata = lock_words[w];
      if (widx == 32'(PG_HWCFG_WORD))
         reg_rdata = {8'(NUM_CHUNKS), 8'(NUM_MASTERS), 8'(NUM_PERIPH), 8'(NUM_ZONES)};
      if (widx == 32'(PG_VERSION_WORD))
         reg_rdata = {24'h0, REVISION};
   end

   a_r8_pad_fields_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == 32'(PG_ATTR_BASE_WORD + ATTR_WORDS - 1)) |-> ((reg_rdata & PAD_MASK) == 32'h0));
   a_r12_owned_matches_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == 32'(PG_ATTR_BASE_WORD)) |-> (acc_owned[0] == !reg_rdata[1]));
endmodule

// File: tb/periph_guard_tb.sv
module periph_guard_tb;
   localparam int N = 20;
   localparam int ZONES = 2, MASTERS = 3, CHUNKS = 1;
   localparam logic [7:0] REV = 8'h20;

   logic clk = 0, rst_n = 0;
   logic [11:0] reg_addr = '0;
   logic reg_we = 0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [N-1:0] acc_ns = '0, acc_wr = '0, acc_grant, acc_owned;

   int checks = 0, errors = 0;
   logic [1:0] exp_attr [N];
   logic       exp_lock [N];

   always #5 clk = ~clk;

   periph_guard #(.NUM_PERIPH(N), .NUM_ZONES(ZONES), .NUM_MASTERS(MASTERS),
                  .NUM_CHUNKS(CHUNKS), .REVISION(REV), .ADDR_W(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_ns(acc_ns),
      .acc_wr(acc_wr), .acc_grant(acc_grant), .acc_owned(acc_owned));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_attr_word(int w);
      logic [31:0] v = '0;
      for (int f = 0; f < 16; f++)
         if (w * 16 + f < N) v[2*f +: 2] = exp_attr[w * 16 + f];
      return v;
   endfunction

   function automatic logic [31:0] model_lock_word();
      logic [31:0] v = '0;
      for (int b = 0; b < N; b++) v[b] = exp_lock[b];
      return v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin exp_attr[i] = 2'd0; exp_lock[i] = 1'b0; end
   endtask

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic bus_read(logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic attr_write(int w, logic [31:0] d);
      for (int f = 0; f < 16; f++)
         if (w * 16 + f < N && !exp_lock[w * 16 + f]) exp_attr[w * 16 + f] = d[2*f +: 2];
      bus_write(12'h010 + 12'(4 * w), d);
   endtask

   task automatic lock_write(logic [31:0] d);
      for (int b = 0; b < N; b++) if (d[b]) exp_lock[b] = 1'b1;
      bus_write(12'h030, d);
   endtask

   task automatic check_regs(string tag);
      logic [31:0] d;
      bus_read(12'h010, d); chk({tag, " attr word0"}, d, model_attr_word(0));
      bus_read(12'h014, d); chk({tag, " attr word1"}, d, model_attr_word(1));
      bus_read(12'h030, d); chk({tag, " lock word"}, d, model_lock_word());
   endtask

   task automatic check_decisions();
      for (int m = 0; m < 4; m++) begin
         acc_ns = {N{m[1]}};
         acc_wr = {N{m[0]}};
         #1;
         for (int i = 0; i < N; i++) begin
            logic eg;
            logic [1:0] a = exp_attr[i];
            if (!m[1]) eg = 1'b1;
            else if (m[0]) eg = (a == 2'd3);
            else eg = (a == 2'd1) || (a == 2'd3);
            chk(!m[1] ? "R11 secure grant" : (m[0] ? "R9 ns write grant" : "R10 ns read grant"),
                32'(acc_grant[i]), 32'(eg));
            chk("R12 owned", 32'(acc_owned[i]), 32'((a == 2'd0) || (a == 2'd1)));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_regs("R1 reset");
      check_decisions();

      // R6 / R7: identification words, write to hwcfg ignored, unmapped zero
      bus_read(12'h3F0, d);
      chk("R6 hwcfg", d, (32'(CHUNKS) << 24) | (32'(MASTERS) << 16) | (32'(N) << 8) | 32'(ZONES));
      bus_read(12'h3F4, d); chk("R7 version", d, {24'h0, REV});
      bus_write(12'h3F0, 32'hFFFF_FFFF);
      bus_read(12'h3F0, d);
      chk("R6 hwcfg after write", d, (32'(CHUNKS) << 24) | (32'(MASTERS) << 16) | (32'(N) << 8) | 32'(ZONES));
      bus_read(12'h3F8, d); chk("R6 unmapped", d, 32'h0);
      bus_read(12'h01C, d); chk("R6 beyond attr words", d, 32'h0);
      check_regs("R6 no side effect");

      // R2 / R8 / R9-R12: sweep every encoding over every peripheral
      for (int e = 0; e < 4; e++) begin
         attr_write(0, {16{2'(e)}});
         attr_write(1, {16{2'(e)}});
         check_regs("R2 R8 sweep");
         check_decisions();
      end
      // R2: distinct per-field values
      attr_write(0, 32'h1B1B_E4E4);
      attr_write(1, 32'hFFFF_FF93);
      check_regs("R2 R8 mixed");
      check_decisions();

      // R13: write and decision in the same cycle
      attr_write(0, 32'hFFFF_FFFF);
      @(negedge clk);
      acc_ns = '1; acc_wr = '1;
      reg_addr = 12'h010; reg_we = 1'b1; reg_wdata = 32'hFFFF_FF3F;
      #3 chk("R13 grant before edge", 32'(acc_grant[3]), 32'h1);
      @(posedge clk);
      #1 chk("R13 grant after edge", 32'(acc_grant[3]), 32'h0);
      chk("R13 neighbour unchanged", 32'(acc_grant[2]), 32'h1);
      @(negedge clk);
      reg_we = 1'b0;
      exp_attr[3] = 2'd0;
      check_regs("R13 readback");

      // R3 / R4: locks freeze only their own fields
      lock_write(32'h0000_0088);
      check_regs("R3 lock set");
      attr_write(0, 32'h0000_0000);
      check_regs("R4 locked fields kept");
      chk("R4 locked id7", 32'(exp_attr[7]), 32'h3);
      check_decisions();

      // R5: zeros do not clear; R8: locks beyond N read zero
      lock_write(32'h0000_0000);
      check_regs("R5 zero write");
      attr_write(0, 32'hAAAA_AAAA);
      check_regs("R4 R5 still locked");
      lock_write(32'hFFF0_0020);
      bus_read(12'h030, d); chk("R8 lock pad bits", d, 32'h0000_00A8);
      bus_read(12'h034, d); chk("R8 lock word1 unmapped", d, 32'h0);
      attr_write(0, 32'h5555_5555);
      check_regs("R4 id5 frozen");
      check_decisions();

      // R5: reset is the only way to clear locks
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      #1 check_regs("R5 R1 reset clears");
      @(negedge clk);
      rst_n = 1'b1;
      attr_write(0, 32'hFFFF_FFFF);
      check_regs("R5 unlocked after reset");
      check_decisions();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule